// File: doc/BRIEF.md
# Boundary-Scan Data Register for an 18-Bit Two-Port Registered Transceiver

This block is the boundary data register of a scan-testable transceiver with two 18-bit ports, A and B, and twelve control inputs. The control inputs form three groups of four: output enables, clocks and latch enables. Each control input owns one cell. Each bidirectional data pin owns two cells: an input cell, which sees the pad or feeds the core, and an output cell, which drives the pad or samples what the core would drive. Together they make 84 cells in a serial chain from `tdi` to `tdo`.

A TAP controller outside this block decodes its state into one-hot capture, shift and update strobes and a Test-Logic-Reset flag. An instruction decoder, also outside, supplies the capture source and a Run-Test/Idle sampling enable. The chain has two stages. The shift stage captures parallel data, serialises it and takes in new data. The update latch copies the shift stage on the update strobe. The update latch alone drives the pad-side and core-side test buses.

Top module: `xcvr_bsr_chain`

## Requirements
- R1: The chain holds 84 cells, indexed 83 down to 0. Bits 83..72 map to `pad_ctrl_i`/`core_ctrl_o` bit i at cell 72+i, where index 11..8 are the output enables, 7..4 the clocks and 3..0 the latch enables. Bits 71..54 are the A input cells and 53..36 the A output cells. Bits 35..18 are the B input cells and 17..0 the B output cells. In each of these four ranges, port bit i sits at the range's low index plus i.
- R2: While `shift_dr` is high, each rising `tck` edge moves every cell one place toward bit 0 and loads `tdi` into bit 83. A pattern shifted in therefore comes out at `tdo` unchanged 84 shifts later.
- R3: `trst_n` low, or `tlr` high at a rising edge, sets both stages to the reset pattern: bits 83..80 are 1 and bits 79..0 are 0.
- R4: `tdo` shows shift-stage bit 0 and changes only on the falling edge of `tck`.
- R5: A capture with `cap_core`=0 loads the pad side. Control cells take `pad_ctrl_i`. The input and output cells of each port both take that port's pad value.
- R6: A capture with `cap_core`=1 loads the core side. Control cells and input cells take the current update-latch values, and the output cells take `core_a_drv_i`/`core_b_drv_i`.
- R7: The update latch loads the whole shift stage on `update_dr` and keeps its value at every other edge. All five parallel outputs come only from the latch.
- R8: With no strobe, no `tlr` and no `idle_sample`, the shift stage keeps its contents whatever `tdi` and the parallel inputs do.
- R9: With `idle_sample` high and no capture, shift or update strobe, the shift stage reloads from the selected capture source at every rising edge (Run-Test/Idle sampling).
- R10: The three strobes are one-hot or idle. `tlr` takes priority over every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | Controller is in Test-Logic-Reset |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| idle_sample | input | 1 | Instruction asks for sampling in Run-Test/Idle |
| cap_core | input | 1 | Capture source: 0 pad side, 1 core side |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| pad_ctrl_i | input | 12 | Control pin pad levels |
| pad_a_i | input | 18 | A-port pad levels |
| pad_b_i | input | 18 | B-port pad levels |
| core_a_drv_i | input | 18 | Data the core would drive onto A |
| core_b_drv_i | input | 18 | Data the core would drive onto B |
| core_ctrl_o | output | 12 | Test values for the core's control inputs |
| core_a_o | output | 18 | Test values for the core's A inputs |
| core_b_o | output | 18 | Test values for the core's B inputs |
| pad_a_o | output | 18 | Test values for the A pads |
| pad_b_o | output | 18 | Test values for the B pads |

## Verification
A captured word reaches the shift stage at the capture's rising edge. Its bit 0 reaches `tdo` at the next falling edge, and each later bit one falling edge after the shift edge that moves it. The bench drives inputs 1 ns after a falling edge and reads `tdo` at that same point, so every bit is read after its falling-edge update and before the next shift edge. The parallel outputs change at the rising edge that carries the update strobe and are read at the following falling edge. One directed check samples `tdo` just after the capture's rising edge, expecting the old value, and again after the falling edge, expecting the new one.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int DEF_PORT_W = 18;
  localparam int DEF_GRP_W  = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_RESET = 2'd1,
    OP_LOAD  = 2'd2,
    OP_SHIFT = 2'd3
  } stage_op_e;
endpackage

// File: rtl/bsr_capture_mux.sv
module bsr_capture_mux #(
  parameter int PORT_W = bsr_pkg::DEF_PORT_W,
  parameter int GRP_W  = bsr_pkg::DEF_GRP_W,
  localparam int CTRL_W = 3 * GRP_W,
  localparam int CELLS  = CTRL_W + 4 * PORT_W
) (
  input  logic              cap_core,
  input  logic [CTRL_W-1:0] pad_ctrl,
  input  logic [PORT_W-1:0] pad_a,
  input  logic [PORT_W-1:0] pad_b,
  input  logic [PORT_W-1:0] core_a_drv,
  input  logic [PORT_W-1:0] core_b_drv,
  input  logic [CELLS-1:0]  latch_q,
  output logic [CELLS-1:0]  cap_vec
);
  // Pad view: each port's pad level feeds both of its cells.
  function automatic logic [CELLS-1:0] pad_view(
    input logic [CTRL_W-1:0] c, input logic [PORT_W-1:0] a, input logic [PORT_W-1:0] b);
    return {c, a, a, b, b};
  endfunction

  // Core view: input-side cells see what the latch feeds the core,
  // output-side cells see what the core would drive.
  function automatic logic [CELLS-1:0] core_view(
    input logic [CELLS-1:0] lq, input logic [PORT_W-1:0] ca, input logic [PORT_W-1:0] cb);
    return {lq[CELLS-1:3*PORT_W], ca, lq[2*PORT_W-1:PORT_W], cb};
  endfunction

  always_comb begin
    if (cap_core) cap_vec = core_view(latch_q, core_a_drv, core_b_drv);
    else          cap_vec = pad_view(pad_ctrl, pad_a, pad_b);
  end
endmodule

// File: rtl/bsr_shift_stage.sv
module bsr_shift_stage #(
  parameter int               CELLS   = 84,
  parameter logic [CELLS-1:0] RST_PAT = '0
) (
  input  logic               tck,
  input  logic               trst_n,
  input  bsr_pkg::stage_op_e op,
  input  logic               tdi,
  input  logic [CELLS-1:0]   cap_vec,
  output logic [CELLS-1:0]   q
);
  import bsr_pkg::*;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      q <= RST_PAT;
    end else begin
      unique case (op)
        OP_RESET: q <= RST_PAT;
        OP_SHIFT: q <= {tdi, q[CELLS-1:1]};
        OP_LOAD:  q <= cap_vec;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/bsr_update_stage.sv
module bsr_update_stage #(
  parameter int               CELLS   = 84,
  parameter logic [CELLS-1:0] RST_PAT = '0
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tlr,
  input  logic             load,
  input  logic [CELLS-1:0] d,
  output logic [CELLS-1:0] q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)   q <= RST_PAT;
    else if (tlr)  q <= RST_PAT;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bsr_tdo_retime.sv
module bsr_tdo_retime #(
  parameter logic RST_BIT = 1'b0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic d,
  output logic tdo
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= RST_BIT;
    else         tdo <= d;
  end
endmodule

// File: rtl/xcvr_bsr_chain.sv
module xcvr_bsr_chain #(
  parameter int PORT_W = bsr_pkg::DEF_PORT_W,
  parameter int GRP_W  = bsr_pkg::DEF_GRP_W,
  localparam int CTRL_W = 3 * GRP_W,
  localparam int CELLS  = CTRL_W + 4 * PORT_W
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tlr,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              idle_sample,
  input  logic              cap_core,
  input  logic              tdi,
  output logic              tdo,
  input  logic [CTRL_W-1:0] pad_ctrl_i,
  input  logic [PORT_W-1:0] pad_a_i,
  input  logic [PORT_W-1:0] pad_b_i,
  input  logic [PORT_W-1:0] core_a_drv_i,
  input  logic [PORT_W-1:0] core_b_drv_i,
  output logic [CTRL_W-1:0] core_ctrl_o,
  output logic [PORT_W-1:0] core_a_o,
  output logic [PORT_W-1:0] core_b_o,
  output logic [PORT_W-1:0] pad_a_o,
  output logic [PORT_W-1:0] pad_b_o
);
  import bsr_pkg::*;

  // Output-enable group (top GRP_W cells) resets high, the rest low.
  localparam logic [CELLS-1:0] RST_PAT = {{GRP_W{1'b1}}, {(CELLS-GRP_W){1'b0}}};

  logic [CELLS-1:0] shift_q;
  logic [CELLS-1:0] upd_q;
  logic [CELLS-1:0] cap_vec;
  stage_op_e        op;

  always_comb begin
    if (tlr)                                           op = OP_RESET;
    else if (shift_dr)                                 op = OP_SHIFT;
    else if (capture_dr || (idle_sample && !update_dr)) op = OP_LOAD;
    else                                               op = OP_HOLD;
  end

  bsr_capture_mux #(.PORT_W(PORT_W), .GRP_W(GRP_W)) u_cap (
    .cap_core   (cap_core),
    .pad_ctrl   (pad_ctrl_i),
    .pad_a      (pad_a_i),
    .pad_b      (pad_b_i),
    .core_a_drv (core_a_drv_i),
    .core_b_drv (core_b_drv_i),
    .latch_q    (upd_q),
    .cap_vec    (cap_vec)
  );

  bsr_shift_stage #(.CELLS(CELLS), .RST_PAT(RST_PAT)) u_shift (
    .tck     (tck),
    .trst_n  (trst_n),
    .op      (op),
    .tdi     (tdi),
    .cap_vec (cap_vec),
    .q       (shift_q)
  );

  bsr_update_stage #(.CELLS(CELLS), .RST_PAT(RST_PAT)) u_upd (
    .tck    (tck),
    .trst_n (trst_n),
    .tlr    (tlr),
    .load   (update_dr),
    .d      (shift_q),
    .q      (upd_q)
  );

  bsr_tdo_retime #(.RST_BIT(RST_PAT[0])) u_tdo (
    .tck    (tck),
    .trst_n (trst_n),
    .d      (shift_q[0]),
    .tdo    (tdo)
  );

  assign core_ctrl_o = upd_q[CELLS-1:4*PORT_W];
  assign core_a_o    = upd_q[4*PORT_W-1:3*PORT_W];
  assign pad_a_o     = upd_q[3*PORT_W-1:2*PORT_W];
  assign core_b_o    = upd_q[2*PORT_W-1:PORT_W];
  assign pad_b_o     = upd_q[PORT_W-1:0];
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int               CELLS   = 84,
  parameter logic [CELLS-1:0] RST_PAT = '0
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tlr,
  input logic             capture_dr,
  input logic             shift_dr,
  input logic             update_dr,
  input logic             idle_sample,
  input logic             tdi,
  input logic             tdo,
  input logic [CELLS-1:0] shift_q,
  input logic [CELLS-1:0] upd_q,
  input logic [CELLS-1:0] cap_vec
);
  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !tlr) |=> (shift_q == {$past(tdi), $past(shift_q[CELLS-1:1])})); // R2
  AST_RESET_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> (shift_q == RST_PAT && upd_q == RST_PAT)); // R3
  AST_TDO_TRACKS_BIT0: assert property (@(posedge tck) disable iff (!trst_n)
    tdo == shift_q[0]); // R4
  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && !tlr) |=> (shift_q == $past(cap_vec))); // R5
  AST_UPDATE_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && !tlr) |=> (upd_q == $past(shift_q))); // R7
  AST_LATCH_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
    (!update_dr && !tlr) |=> $stable(upd_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (!capture_dr && !shift_dr && !tlr && !idle_sample) |=> $stable(shift_q)); // R8
  AST_RTI_SAMPLE: assert property (@(posedge tck) disable iff (!trst_n)
    (idle_sample && !capture_dr && !shift_dr && !update_dr && !tlr) |=> (shift_q == $past(cap_vec))); // R9
  AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({capture_dr, shift_dr, update_dr})); // R10
endmodule

bind xcvr_bsr_chain bsr_chain_chk #(.CELLS(CELLS), .RST_PAT(RST_PAT)) u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .tlr         (tlr),
  .capture_dr  (capture_dr),
  .shift_dr    (shift_dr),
  .update_dr   (update_dr),
  .idle_sample (idle_sample),
  .tdi         (tdi),
  .tdo         (tdo),
  .shift_q     (shift_q),
  .upd_q       (upd_q),
  .cap_vec     (cap_vec)
);

// File: tb/xcvr_bsr_chain_bench.sv
module xcvr_bsr_chain_bench;
  localparam int N = 84;

  logic tck = 1'b0;
  logic trst_n = 1'b0, tlr = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic idle_sample = 1'b0, cap_core = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [11:0] pad_ctrl_i = '0;
  logic [17:0] pad_a_i = '0, pad_b_i = '0, core_a_drv_i = '0, core_b_drv_i = '0;
  logic [11:0] core_ctrl_o;
  logic [17:0] core_a_o, core_b_o, pad_a_o, pad_b_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 tck = ~tck;

  xcvr_bsr_chain u_xcvr_bsr_chain (.*);

  // Vector: {core_mode, ctrl[11:0], pad_a, pad_b, core_a, core_b}
  localparam logic [84:0] VEC [0:3] = '{
    {1'b0, 12'hA5C, 18'h2AAAA, 18'h15555, 18'h3F00F, 18'h00FF0},
    {1'b1, 12'h3C3, 18'h0F0F0, 18'h33333, 18'h2D2D2, 18'h1E1E1},
    {1'b0, 12'hFFF, 18'h3FFFF, 18'h00001, 18'h00000, 18'h3FFFF},
    {1'b1, 12'h001, 18'h10000, 18'h3FFFE, 18'h12345, 18'h2BCDE}
  };

  function automatic logic [N-1:0] reset_pat();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = (k >= 80);
    return v;
  endfunction

  // Expected capture word, built cell by cell from the R1 bit map.
  function automatic logic [N-1:0] expect_cap(input logic m, input logic [11:0] c,
      input logic [17:0] a, input logic [17:0] b, input logic [17:0] ca,
      input logic [17:0] cb, input logic [N-1:0] lat);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) begin
      if (k >= 72)      v[k] = m ? lat[k] : c[k-72];
      else if (k >= 54) v[k] = m ? lat[k] : a[k-54];
      else if (k >= 36) v[k] = m ? ca[k-36] : a[k-36];
      else if (k >= 18) v[k] = m ? lat[k] : b[k-18];
      else              v[k] = m ? cb[k] : b[k];
    end
    return v;
  endfunction

  function automatic logic [N-1:0] outs();
    return {core_ctrl_o, core_a_o, pad_a_o, core_b_o, pad_b_o};
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge tck);
    #1;
  endtask

  task automatic shift84(input logic [N-1:0] din, output logic [N-1:0] dout);
    for (int i = 0; i < N; i++) begin
      dout[i] = tdo;
      shift_dr = 1'b1;
      tdi = din[i];
      step();
    end
    shift_dr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic capture(input logic m);
    cap_core = m;
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
  endtask

  task automatic update();
    update_dr = 1'b1;
    step();
    update_dr = 1'b0;
  endtask

  initial begin
    logic [N-1:0] got, lat_exp, din, pat;
    repeat (3) step();
    trst_n = 1'b1;
    step();

    // R3: latch outputs and chain contents after reset
    check("R3 outputs after reset", outs(), reset_pat());
    shift84('0, got);
    check("R3 chain after reset", got, reset_pat());
    lat_exp = reset_pat();

    // R4: tdo moves on the falling edge only (chain now all zero)
    pad_b_i = 18'h00001;
    cap_core = 1'b0;
    capture_dr = 1'b1;
    @(posedge tck); #1;
    check("R4 tdo before falling edge", {83'b0, tdo}, {83'b0, 1'b0});
    @(negedge tck); #1;
    capture_dr = 1'b0;
    check("R4 tdo after falling edge", {83'b0, tdo}, {83'b0, 1'b1});

    // Table walk: capture (R5/R6), shift out, update (R7, R1)
    for (int i = 0; i < 4; i++) begin
      {cap_core, pad_ctrl_i, pad_a_i, pad_b_i, core_a_drv_i, core_b_drv_i} = VEC[i];
      capture(VEC[i][84]);
      din = VEC[i][83:0] ^ {21{4'h9}};
      shift84(din, got);
      check(VEC[i][84] ? "R6 core-side capture" : "R5 pad-side capture", got,
            expect_cap(VEC[i][84], VEC[i][83:72], VEC[i][71:54], VEC[i][53:36],
                       VEC[i][35:18], VEC[i][17:0], lat_exp));
      update();
      check("R7 R1 latch outputs after update", outs(), din);
      lat_exp = din;
    end

    // R2: pattern comes back out at tdo after 84 shifts
    pat = {21{4'hC}} ^ {12'h5A5, 72'h0123456789ABCDEF01};
    shift84(pat, got);
    shift84('0, got);
    check("R2 shift-through", got, pat);

    // R7: shifting without update leaves outputs unchanged
    check("R7 outputs untouched by shifting", outs(), lat_exp);

    // R8: hold while idle with moving inputs
    shift84(pat, got);
    for (int k = 0; k < 5; k++) begin
      tdi = k[0];
      pad_a_i = 18'h3FFFF ^ 18'(k);
      step();
    end
    tdi = 1'b0;
    shift84('0, got);
    check("R8 hold when idle", got, pat);

    // R9: Run-Test/Idle sampling of the pad side
    pad_ctrl_i = 12'h6E1; pad_a_i = 18'h2468A; pad_b_i = 18'h13579;
    cap_core = 1'b0;
    idle_sample = 1'b1;
    step(); step();
    idle_sample = 1'b0;
    shift84('0, got);
    check("R9 idle sampling", got,
          expect_cap(1'b0, 12'h6E1, 18'h2468A, 18'h13579, 18'h0, 18'h0, lat_exp));

    // R10: tlr wins over a concurrent shift strobe
    shift84(pat, got);
    update();
    tlr = 1'b1;
    shift_dr = 1'b1;
    tdi = 1'b1;
    step();
    tlr = 1'b0;
    shift_dr = 1'b0;
    tdi = 1'b0;
    check("R10 R3 outputs after tlr", outs(), reset_pat());
    shift84('0, got);
    check("R10 R3 chain after tlr", got, reset_pat());

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule